// File: doc/BRIEF.md
# ADC Conversion Control and Status

This block is the control and status logic that sits between a processor's register port and an analog-to-digital conversion engine. Software programs a control byte and a mode field, launches conversions by a register write or by one of three external trigger lines, and reads completion, pause and busy state back. The block drives a one-cycle start pulse to the converter. It takes a done pulse with a result from the converter and keeps the last result in a single result register.

Conversions run in single mode, continuous mode or stop mode. When a result is stored, the block sets a completion flag. It presents an interrupt level and, when DMA is enabled, a one-cycle DMA request. The result register holds one entry only, so a newly finished result is parked while the previous one still waits for DMA. In that state the pause flag rises, conversion halts, and the parked result is stored once the DMA acknowledge arrives.

Top module: `adc_ctl_status`

## Requirements
- R1: The register word reads as follows. Bit 7 is busy, bit 6 is the completion flag, bit 5 is the interrupt enable and bit 4 is pause. Bits 3..2 are the trigger select, bit 1 is the start bit and always reads 0, and bit 0 reads 0. Bits 9..8 are the mode: 00 single, 01 continuous, 10 or 11 stop. Bits 15..10 read 0. After reset every bit, `irq`, `dma_req` and `result` are 0.
- R2: A start sets busy and issues exactly one `conv_start` pulse. In single mode, busy clears when that conversion's done pulse arrives. The result is then stored and the completion flag sets.
- R3: In continuous and stop modes, busy stays 1 after a conversion completes. Continuous mode relaunches on its own. Stop mode waits for the next trigger.
- R4: A read with `rd_rmw`=1 returns bit 7 as 1, whatever the busy state.
- R5: A control write (`wr_be[0]`) with bit 7=0 while busy clears busy and ends the conversion in flight. Its done pulse is discarded. Bit 7=0 together with bit 1=1 never starts a conversion.
- R6: `irq` is the completion flag ANDed with the interrupt enable. With `dma_en`=1, `dma_req` pulses for one cycle, one cycle after each store. With `dma_en`=0, `dma_req` stays 0.
- R7: Writing 0 to bit 6 clears the flag only while busy is 0. With `dma_en`=1, a `dma_ack` pulse clears the flag.
- R8: A conversion that finishes while a stored result still awaits `dma_ack` is held back. Pause sets, `result` stays unchanged and no new start is issued. On `dma_ack`, pause clears. The held value is stored one cycle later.
- R9: Trigger select 00 picks software start, a control write with bit 7=1 and bit 1=1. The select value checked is the one held before that write. Selects 01, 10 and 11 pick `ext_trig[0]`, `ext_trig[1]` and `ext_trig[2]`. A trigger that arrives while a conversion is in flight is ignored.
- R10: Writes to the trigger select and mode are ignored while busy is 1. The interrupt enable is writable at any time. Pause cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables: [0] control byte, [1] mode byte |
| wr_data | input | 16 | Write data |
| rd_rmw | input | 1 | Current read belongs to a read-modify-write |
| rd_data | output | 16 | Register read value |
| ext_trig | input | 3 | External trigger pulses |
| conv_start | output | 1 | Start pulse to converter |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | RES_W | Converter result, valid with done |
| dma_en | input | 1 | DMA activation enabled |
| dma_ack | input | 1 | End-of-transfer pulse from DMA |
| dma_req | output | 1 | DMA request pulse |
| irq | output | 1 | Interrupt request level |
| result | output | RES_W | Result register |

## Verification
Every combination of trigger select and trigger line is swept. This separates the correct line mapping from a shifted or swapped decode. Software start is tried under each external select, and the illegal abort-plus-start write is tried on its own, which exposes a start path that ignores the select or the busy bit. Each mode is run to completion, then aborted mid-conversion. That separates automatic busy clearing from software-only clearing, and a discarded result from a leaked one. A DMA run holds back a second result and checks the exact cycle in which the parked value lands after the acknowledge.

// File: rtl/adc_ctl_status.sv
module adc_ctl_status #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [15:0]      wr_data,
  input  logic             rd_rmw,
  output logic [15:0]      rd_data,
  input  logic [2:0]       ext_trig,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             dma_en,
  input  logic             dma_ack,
  output logic             dma_req,
  output logic             irq,
  output logic [RES_W-1:0] result
);

  logic             busy_q, flag_q, inte_q, pause_q, conv_q, held_q, pend_q;
  logic [1:0]       sel_q, mode_q;
  logic [RES_W-1:0] hold_d, res_q;

  logic wr_c, wr_m, abort, sw_trig, ext_hit, trig, cont, single;
  logic launch, done_ok, pend_eff, park, take_held, store;

  assign wr_c    = wr_en & wr_be[0];
  assign wr_m    = wr_en & wr_be[1];
  assign abort   = wr_c & ~wr_data[7] & busy_q;
  assign sw_trig = wr_c & wr_data[7] & wr_data[1] & (sel_q == 2'b00);

  always_comb begin
    case (sel_q)
      2'b01:   ext_hit = ext_trig[0];
      2'b10:   ext_hit = ext_trig[1];
      2'b11:   ext_hit = ext_trig[2];
      default: ext_hit = 1'b0;
    endcase
  end

  assign trig      = sw_trig | ext_hit;
  assign cont      = (mode_q == 2'b01);
  assign single    = (mode_q == 2'b00);
  assign launch    = ~conv_q & ~held_q & ~abort & (trig | (busy_q & cont));
  assign done_ok   = conv_q & conv_done & ~abort;
  assign pend_eff  = pend_q & ~dma_ack;
  assign park      = done_ok & pend_eff;
  assign take_held = held_q & ~pause_q;
  assign store     = (done_ok & ~pend_eff) | take_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      inte_q  <= 1'b0;
      pause_q <= 1'b0;
      conv_q  <= 1'b0;
      held_q  <= 1'b0;
      pend_q  <= 1'b0;
      sel_q   <= 2'b00;
      mode_q  <= 2'b00;
      hold_d  <= '0;
      res_q   <= '0;
      dma_req <= 1'b0;
    end else begin
      if (abort)                 busy_q <= 1'b0;
      else if (launch)           busy_q <= 1'b1;
      else if (done_ok & single) busy_q <= 1'b0;

      if (abort)        conv_q <= 1'b0;
      else if (launch)  conv_q <= 1'b1;
      else if (done_ok) conv_q <= 1'b0;

      if (store)                                   flag_q <= 1'b1;
      else if (dma_en & dma_ack)                   flag_q <= 1'b0;
      else if (wr_c & ~wr_data[6] & ~busy_q)       flag_q <= 1'b0;

      if (wr_c)           inte_q <= wr_data[5];
      if (wr_c & ~busy_q) sel_q  <= wr_data[3:2];
      if (wr_m & ~busy_q) mode_q <= wr_data[9:8];

      if (store)        pend_q <= dma_en;
      else if (dma_ack) pend_q <= 1'b0;

      if (park)           held_q <= 1'b1;
      else if (take_held) held_q <= 1'b0;
      if (park)           hold_d <= conv_result;

      if (park)         pause_q <= 1'b1;
      else if (dma_ack) pause_q <= 1'b0;

      if (store) res_q <= held_q ? hold_d : conv_result;
      dma_req <= store & dma_en;
    end
  end

  assign conv_start = launch;
  assign irq        = flag_q & inte_q;
  assign result     = res_q;
  assign rd_data    = {6'b0, mode_q, busy_q | rd_rmw, flag_q, inte_q, pause_q, sel_q, 2'b00};

endmodule

// File: rtl/adc_ctl_status_chk.sv
module adc_ctl_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_be,
  input logic [15:0] wr_data,
  input logic        rd_rmw,
  input logic [15:0] rd_data,
  input logic        conv_start,
  input logic        conv_done,
  input logic        dma_req,
  input logic        busy,
  input logic        conv,
  input logic        flag,
  input logic        pause,
  input logic [1:0]  mode
);

  logic abort_wr;
  assign abort_wr = wr_en && wr_be[0] && !wr_data[7];

  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (busy && conv));

  p_single_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && conv_done && mode == 2'b00) |=> !busy);

  p_busy_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode != 2'b00 && !abort_wr) |=> busy);

  p_rmw_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rmw |-> rd_data[7]);

  p_abort_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |-> !conv_start);

  p_abort_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> !busy);

  p_req_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> flag);

  p_pause_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> !conv_start);

endmodule

bind adc_ctl_status adc_ctl_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
  .rd_rmw(rd_rmw), .rd_data(rd_data), .conv_start(conv_start), .conv_done(conv_done),
  .dma_req(dma_req), .busy(busy_q), .conv(conv_q), .flag(flag_q), .pause(pause_q),
  .mode(mode_q)
);

// File: tb/test_adc_ctl_status.sv
module test_adc_ctl_status;
  localparam int CLK_P = 10;
  localparam int RES_W = 10;
  localparam int LAT   = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_rmw = 0, dma_en = 0, dma_ack = 0;
  logic [1:0] wr_be = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [2:0] ext_trig = 0;
  logic conv_start, conv_done = 0, dma_req, irq;
  logic [RES_W-1:0] conv_result = 0, result, val = 0;
  int cnt = 0, n_start = 0, n_req = 0, n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_ctl_status #(.RES_W(RES_W)) i_adc_ctl_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_rmw(rd_rmw), .rd_data(rd_data), .ext_trig(ext_trig), .conv_start(conv_start),
    .conv_done(conv_done), .conv_result(conv_result), .dma_en(dma_en), .dma_ack(dma_ack),
    .dma_req(dma_req), .irq(irq), .result(result));

  function automatic logic [RES_W-1:0] fval(int idx);
    return RES_W'(idx * 37 + 5);
  endfunction

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (dma_req) n_req <= n_req + 1;
    if (conv_start) begin
      n_start <= n_start + 1;
      cnt <= LAT;
      val <= fval(n_start + 1);
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        conv_done <= 1'b1;
        conv_result <= val;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_be = 0; wr_data = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n0;
    idle(2);
    rst_n = 1;
    idle(1);
    check("R1 reset rd_data", rd_data, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset result", result, 0);
    check("R1 reset dma_req", dma_req, 0);
    rd_rmw = 1; #1;
    check("R4 rmw busy", rd_data[7], 1);
    rd_rmw = 0;

    // R2 single software start
    wr(2'b01, 16'h00A2);
    check("R2 busy set", rd_data[7], 1);
    check("R2 one start", n_start, 1);
    check("R1 start bit reads 0", rd_data[1:0], 0);
    idle(8);
    check("R2 busy cleared", rd_data[7], 0);
    check("R2 flag set", rd_data[6], 1);
    check("R6 irq level", irq, 1);
    check("R2 result", result, fval(1));
    check("R6 no dma_req without dma_en", n_req, 0);

    // R7 flag clear while idle
    wr(2'b01, 16'h0020);
    check("R7 flag cleared idle", rd_data[6], 0);
    check("R6 irq drops", irq, 0);

    // R5 illegal abort plus start
    n0 = n_start;
    wr(2'b01, 16'h0022);
    idle(6);
    check("R5 abort+start no start", n_start, n0);
    check("R5 busy stays 0", rd_data[7], 0);

    // R9 select sweep
    for (int s = 1; s < 4; s++) begin
      wr(2'b01, 16'h0020 | 16'(s << 2));
      check("R9 select written", rd_data[3:2], s);
      for (int ln = 0; ln < 3; ln++) begin
        n0 = n_start;
        @(negedge clk); ext_trig = 3'(1 << ln);
        @(negedge clk); ext_trig = 0;
        idle(8);
        check("R9 ext line mapping", n_start - n0, (ln == s - 1) ? 1 : 0);
        if (ln == s - 1) check("R9 ext result", result, fval(n_start));
      end
      n0 = n_start;
      wr(2'b01, 16'h00A2 | 16'(s << 2));
      idle(8);
      check("R9 sw start ignored with ext select", n_start - n0, 0);
    end
    wr(2'b01, 16'h0020);

    // R9 trigger during conversion ignored
    n0 = n_start;
    wr(2'b01, 16'h00A2);
    wr(2'b01, 16'h00A2);
    idle(8);
    check("R9 retrigger in flight ignored", n_start - n0, 1);

    // R3 stop mode
    wr(2'b10, 16'h0200);
    check("R1 mode field", rd_data[9:8], 2);
    n0 = n_start;
    wr(2'b01, 16'h00A2);
    idle(8);
    check("R3 stop busy stays", rd_data[7], 1);
    check("R3 stop one conversion", n_start - n0, 1);
    check("R2 stop flag", rd_data[6], 1);
    wr(2'b01, 16'h00A0);
    check("R7 flag clear ignored while busy", rd_data[6], 1);
    wr(2'b01, 16'h00AC);
    check("R10 select locked while busy", rd_data[3:2], 0);
    wr(2'b10, 16'h0100);
    check("R10 mode locked while busy", rd_data[9:8], 2);
    wr(2'b01, 16'h0090);
    check("R10 inte writable while busy", rd_data[5], 0);
    check("R10 pause not writable", rd_data[4], 0);
    check("R6 irq off with inte 0", irq, 0);
    idle(8);
    check("R3 stop waits for trigger", n_start - n0, 1);
    wr(2'b01, 16'h00A2);
    idle(8);
    check("R3 stop retrigger", n_start - n0, 2);
    check("R3 stop result", result, fval(n_start));
    n0 = n_start;
    wr(2'b01, 16'h00A2);
    wr(2'b01, 16'h0020);
    check("R5 abort clears busy", rd_data[7], 0);
    idle(8);
    check("R5 aborted result discarded", result, fval(n0));
    check("R5 no further start", n_start - n0, 1);

    // R3 continuous
    wr(2'b01, 16'h0020);
    wr(2'b10, 16'h0100);
    n0 = n_start;
    wr(2'b01, 16'h00A2);
    idle(20);
    check("R3 continuous busy", rd_data[7], 1);
    check("R3 continuous relaunch", (n_start - n0) >= 3, 1);
    wr(2'b01, 16'h0020);
    n0 = n_start;
    idle(12);
    check("R5 continuous abort stops", n_start - n0, 0);
    check("R5 continuous busy cleared", rd_data[7], 0);

    // R8 DMA back-pressure
    wr(2'b01, 16'h0020);
    dma_en = 1;
    n0 = n_start;
    wr(2'b01, 16'h00A2);
    idle(20);
    check("R8 pause set", rd_data[4], 1);
    check("R8 halted starts", n_start - n0, 2);
    check("R8 first result kept", result, fval(n0 + 1));
    check("R6 one dma_req", n_req, 1);
    check("R6 flag with dma", rd_data[6], 1);
    @(negedge clk); dma_ack = 1;
    @(negedge clk); dma_ack = 0;
    check("R8 pause cleared on ack", rd_data[4], 0);
    check("R7 ack clears flag", rd_data[6], 0);
    check("R8 result not yet replaced", result, fval(n0 + 1));
    @(negedge clk);
    check("R8 held result stored", result, fval(n0 + 2));
    check("R6 flag after held store", rd_data[6], 1);
    check("R6 dma_req pulse", dma_req, 1);
    @(negedge clk);
    check("R6 dma_req one cycle", dma_req, 0);
    wr(2'b01, 16'h0020);
    dma_en = 0;
    idle(4);
    summary();
  end
endmodule